// File: doc/BRIEF.md
# Motor Pin Half-Duplex Serial Bridge

This block shares each motor output pin between two uses. In normal flight operation every pin carries a pulse-protocol motor signal that an external generator supplies. For speed-controller firmware maintenance, one chosen pin is turned into a single-wire, half-duplex UART. The host can then talk to the bootloader on the far end through a byte transmit port and a byte receive port. A control register chooses the pin mode and the serviced channel. The same register can hold the serviced line low for as long as the host wants, which sends the break that makes the far end enter its bootloader.

In serial mode the block drives the shared wire only while a frame is being sent. After the stop bit it keeps its receiver blanked for a guard period, then releases the wire and starts listening again without any help from the host. The receiver is held idle for the whole transmit period, so the block never decodes its own echo. A start bit must still be low at mid-bit to be accepted. A stop bit that reads low throws the byte away and latches an error flag.

Top module: `motor_pin_uart_bridge`

## Requirements
- R1: After reset the control register reads 0x1 (pulse mode, channel 0, no break). Every pin is driven (pinOe all ones) with pinOut equal to pulseIn. txBusy, rxValid and frameErr are 0.
- R2: Control register decode. Bit 2 set selects serial mode, even when bit 0 is also set. Bit 0 alone selects pulse mode, where every pin is driven with its pulseIn bit. Neither bit set drives every pin low. Bits 0, 2 and 4 and the channel field read back unchanged.
- R3: In serial mode the channel field (bits [8 +: log2(NUM_CH)], bits 9:8 for four channels) names the serviced pin. Every other pin stays driven with its own pulseIn bit.
- R4: In serial mode, with bit 4 clear and no frame on the wire, the serviced pin is released (pinOe 0) with pinOut at the idle-high level 1.
- R5: In serial mode with bit 4 set, the serviced pin is driven low for as long as the bit stays set, with no timeout. This overrides any frame in progress.
- R6: A txValid pulse is accepted when the block is in serial mode with bit 4 clear and txBusy low. From the next cycle the serviced pin is driven with a start bit 0, the eight data bits LSB first, and a stop bit 1, each held for CLKS_PER_BIT cycles.
- R7: After the stop bit the pin is released for GUARD_BITS bit times while txBusy stays 1. txBusy falls when this guard period ends. A txValid pulse seen while txBusy is 1 is ignored.
- R8: A txValid pulse is ignored while bit 4 is set or serial mode is off: txBusy stays 0 and no frame is sent.
- R9: No byte is received from line activity while txBusy is 1, so the block's own frame is never captured.
- R10: A well-formed frame arriving on the serviced pin (start 0, 8 data bits LSB first, stop 1) produces exactly one one-cycle rxValid pulse with the byte on rxData.
- R11: A frame whose stop bit reads 0 produces no rxValid and sets frameErr. frameErr stays 1 until reset, also across later good frames.
- R12: The receiver ignores the line while bit 4 is set and while serial mode is off.
- R13: A low level on the line that returns high before half a bit time has passed is rejected as a false start. It produces no byte and no framing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 32 | Control register write value |
| regRdData | output | 32 | Control register read value |
| pulseIn | input | NUM_CH | Pulse-protocol motor signal per channel |
| txData | input | 8 | Byte to transmit |
| txValid | input | 1 | Transmit request, sampled when the block can accept it |
| txBusy | output | 1 | High from the start bit until the guard period ends |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle strobe for a received byte |
| frameErr | output | 1 | Sticky framing error flag |
| pinIn | input | NUM_CH | Level seen on each pin |
| pinOut | output | NUM_CH | Value driven on each pin |
| pinOe | output | NUM_CH | Output enable per pin |

## Verification
The bench builds the bridge with NUM_CH=4, CLKS_PER_BIT=32 and GUARD_BITS=2. At 32 clocks per bit the oversampling tick is two clocks, so a full frame takes a few hundred cycles. This leaves room for dozens of transmit and receive frames, a break held for thousands of cycles, and false-start, framing-error and mid-frame override cases in one run. A two-bit guard keeps the released-but-busy window clearly apart from the stop bit. Four channels let the channel field move the serviced pin while its neighbours show their own pulse inputs.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

  localparam int CTRL_PULSE_BIT  = 0;
  localparam int CTRL_SERIAL_BIT = 2;
  localparam int CTRL_FORCE_BIT  = 4;
  localparam int CTRL_CHSEL_LSB  = 8;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_PULSE  = 2'd1,
    MODE_SERIAL = 2'd2
  } pin_mode_e;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_FRAME,
    TX_GUARD
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic txDrive;
    logic rxShift;
    logic rxCommit;
  } strobe_t;

endpackage

// File: rtl/mpb_ctrl.sv
module mpb_ctrl
  import mpb_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int CLKS_PER_BIT = 160,
  parameter int GUARD_BITS   = 1,
  localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            regWrEn,
  input  logic [31:0]     regWrData,
  output logic [31:0]     regRdData,
  input  logic            txValid,
  input  logic            rxLine,
  output strobe_t         strb,
  output pin_mode_e       pinMode,
  output logic            forceBit,
  output logic [CH_W-1:0] chSel,
  output logic            txBusy,
  output logic            rxValid,
  output logic            frameErr
);

  localparam int BIT_W      = $clog2(CLKS_PER_BIT);
  localparam int GUARD_CLKS = GUARD_BITS * CLKS_PER_BIT;
  localparam int GUARD_W    = $clog2(GUARD_CLKS + 1);
  localparam int TICK       = CLKS_PER_BIT / 16;
  localparam int TICK_W     = $clog2(TICK + 1);

  // ---------------- control register ----------------
  logic pulseBit, serialBit;
  logic unusedWrBits;
  assign unusedWrBits = ^{regWrData[31:CTRL_CHSEL_LSB+CH_W], regWrData[7:5],
                          regWrData[3], regWrData[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulseBit  <= 1'b1;
      serialBit <= 1'b0;
      forceBit  <= 1'b0;
      chSel     <= '0;
    end else if (regWrEn) begin
      pulseBit  <= regWrData[CTRL_PULSE_BIT];
      serialBit <= regWrData[CTRL_SERIAL_BIT];
      forceBit  <= regWrData[CTRL_FORCE_BIT];
      chSel     <= regWrData[CTRL_CHSEL_LSB +: CH_W];
    end
  end

  always_comb begin
    regRdData = '0;
    regRdData[CTRL_PULSE_BIT]          = pulseBit;
    regRdData[CTRL_SERIAL_BIT]         = serialBit;
    regRdData[CTRL_FORCE_BIT]          = forceBit;
    regRdData[CTRL_CHSEL_LSB +: CH_W]  = chSel;
  end

  logic isSerial;
  assign isSerial = serialBit;
  assign pinMode  = serialBit ? MODE_SERIAL : (pulseBit ? MODE_PULSE : MODE_OFF);

  // ---------------- transmit sequencer ----------------
  tx_state_e          txState;
  logic [BIT_W-1:0]   bitTimer;
  logic [3:0]         bitIdx;
  logic [GUARD_W-1:0] guardTimer;
  logic               txAccept, bitEnd;

  assign txAccept = txValid && (txState == TX_IDLE) && isSerial && !forceBit;
  assign bitEnd   = (bitTimer == BIT_W'(CLKS_PER_BIT - 1));
  assign txBusy   = (txState != TX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txState    <= TX_IDLE;
      bitTimer   <= '0;
      bitIdx     <= '0;
      guardTimer <= '0;
    end else begin
      case (txState)
        TX_IDLE: begin
          if (txAccept) begin
            txState  <= TX_FRAME;
            bitTimer <= '0;
            bitIdx   <= '0;
          end
        end
        TX_FRAME: begin
          if (bitEnd) begin
            bitTimer <= '0;
            if (bitIdx == 4'd9) begin
              txState    <= TX_GUARD;
              guardTimer <= '0;
            end else begin
              bitIdx <= bitIdx + 4'd1;
            end
          end else begin
            bitTimer <= bitTimer + BIT_W'(1);
          end
        end
        default: begin
          if (guardTimer == GUARD_W'(GUARD_CLKS - 1)) txState <= TX_IDLE;
          else guardTimer <= guardTimer + GUARD_W'(1);
        end
      endcase
    end
  end

  // ---------------- receive sequencer ----------------
  rx_state_e         rxState;
  logic [TICK_W-1:0] tickDiv;
  logic [3:0]        subCnt;
  logic [2:0]        rxIdx;
  logic              rxBlock, tick, midBit;

  assign rxBlock = txBusy || txAccept || forceBit || !isSerial;
  assign tick    = (tickDiv == TICK_W'(TICK - 1));
  assign midBit  = tick && (subCnt == 4'hF);

  always_comb begin
    strb.txLoad   = txAccept;
    strb.txShift  = (txState == TX_FRAME) && bitEnd && (bitIdx != 4'd9);
    strb.txDrive  = (txState == TX_FRAME);
    strb.rxShift  = !rxBlock && (rxState == RX_DATA) && midBit;
    strb.rxCommit = !rxBlock && (rxState == RX_STOP) && midBit && rxLine;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxState  <= RX_IDLE;
      tickDiv  <= '0;
      subCnt   <= '0;
      rxIdx    <= '0;
      rxValid  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      rxValid <= strb.rxCommit;
      if (rxBlock) begin
        rxState <= RX_IDLE;
        tickDiv <= '0;
        subCnt  <= '0;
      end else if (rxState == RX_IDLE) begin
        if (!rxLine) begin
          rxState <= RX_START;
          tickDiv <= '0;
          subCnt  <= '0;
        end
      end else begin
        tickDiv <= tick ? '0 : tickDiv + TICK_W'(1);
        if (tick) subCnt <= subCnt + 4'd1;
        // start bit must still be low at its middle (8th tick)
        if (rxState == RX_START && tick && subCnt == 4'd7) begin
          subCnt  <= '0;
          rxIdx   <= '0;
          rxState <= rxLine ? RX_IDLE : RX_DATA;
        end
        if (rxState == RX_DATA && midBit) begin
          rxIdx <= rxIdx + 3'd1;
          if (rxIdx == 3'd7) rxState <= RX_STOP;
        end
        if (rxState == RX_STOP && midBit) begin
          rxState <= RX_IDLE;
          if (!rxLine) frameErr <= 1'b1;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  assert_rx_blanked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    txBusy |-> (rxState == RX_IDLE));

  assert_rxvalid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> !rxValid);

  assert_ferr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frameErr |=> frameErr);

  assert_tx_start_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txBusy) |-> $past(isSerial && !forceBit));

endmodule

// File: rtl/mpb_datapath.sv
module mpb_datapath
  import mpb_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [7:0]        txData,
  input  pin_mode_e         pinMode,
  input  logic              forceBit,
  input  logic [CH_W-1:0]   chSel,
  input  logic [NUM_CH-1:0] pulseIn,
  input  logic [NUM_CH-1:0] pinIn,
  output logic [NUM_CH-1:0] pinOut,
  output logic [NUM_CH-1:0] pinOe,
  output logic              rxLine,
  output logic [7:0]        rxData
);

  // transmit shift register: stop, data, start (start at LSB)
  logic [9:0] txSr;
  logic       txLine;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            txSr <= '1;
    else if (strb.txLoad)  txSr <= {1'b1, txData, 1'b0};
    else if (strb.txShift) txSr <= {1'b1, txSr[9:1]};
  end
  assign txLine = txSr[0];

  // receive synchroniser on the serviced pin
  logic [1:0] syncQ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= 2'b11;
    else        syncQ <= {syncQ[0], pinIn[chSel]};
  end
  assign rxLine = syncQ[1];

  logic [7:0] rxSr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxSr   <= '0;
      rxData <= '0;
    end else begin
      if (strb.rxShift)  rxSr   <= {rxLine, rxSr[7:1]};
      if (strb.rxCommit) rxData <= rxSr;
    end
  end

  // per-channel pin mux
  for (genvar g = 0; g < NUM_CH; g++) begin : g_pin
    always_comb begin
      if (pinMode == MODE_SERIAL && chSel == CH_W'(g)) begin
        if (forceBit) begin
          pinOe[g]  = 1'b1;
          pinOut[g] = 1'b0;
        end else if (strb.txDrive) begin
          pinOe[g]  = 1'b1;
          pinOut[g] = txLine;
        end else begin
          pinOe[g]  = 1'b0;
          pinOut[g] = 1'b1;
        end
      end else if (pinMode == MODE_OFF) begin
        pinOe[g]  = 1'b1;
        pinOut[g] = 1'b0;
      end else begin
        pinOe[g]  = 1'b1;
        pinOut[g] = pulseIn[g];
      end
    end
  end

  // ---------------- assertions ----------------
  assert_break_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pinMode == MODE_SERIAL && forceBit) |-> (pinOe[chSel] && !pinOut[chSel]));

  assert_idle_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pinMode == MODE_SERIAL && !forceBit && !strb.txDrive) |-> (!pinOe[chSel] && pinOut[chSel]));

endmodule

// File: rtl/motor_pin_uart_bridge.sv
module motor_pin_uart_bridge
  import mpb_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int CLKS_PER_BIT = 160,
  parameter int GUARD_BITS   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [NUM_CH-1:0] pulseIn,
  input  logic [7:0]        txData,
  input  logic              txValid,
  output logic              txBusy,
  output logic [7:0]        rxData,
  output logic              rxValid,
  output logic              frameErr,
  input  logic [NUM_CH-1:0] pinIn,
  output logic [NUM_CH-1:0] pinOut,
  output logic [NUM_CH-1:0] pinOe
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  strobe_t         strb;
  pin_mode_e       pinMode;
  logic            forceBit;
  logic [CH_W-1:0] chSel;
  logic            rxLine;

  mpb_ctrl #(
    .NUM_CH(NUM_CH), .CLKS_PER_BIT(CLKS_PER_BIT), .GUARD_BITS(GUARD_BITS)
  ) u_ctrl (
    .clk, .rst_n, .regWrEn, .regWrData, .regRdData, .txValid, .rxLine,
    .strb, .pinMode, .forceBit, .chSel, .txBusy, .rxValid, .frameErr
  );

  mpb_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk, .rst_n, .strb, .txData, .pinMode, .forceBit, .chSel,
    .pulseIn, .pinIn, .pinOut, .pinOe, .rxLine, .rxData
  );

endmodule

// File: tb/motor_pin_uart_bridge_tb.sv
module motor_pin_uart_bridge_tb;

  localparam int NUM_CH = 4;
  localparam int CPB    = 32;
  localparam int GUARD  = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        regWrEn;
  logic [31:0] regWrData, regRdData;
  logic [3:0]  pulseIn, pinIn, pinOut, pinOe, extLine;
  logic [7:0]  txData, rxData;
  logic        txValid, txBusy, rxValid, frameErr;

  always #4 clk = ~clk;  // 125 MHz

  // wire model: driven value when enabled, else external level
  assign pinIn = (pinOe & pinOut) | (~pinOe & extLine);

  motor_pin_uart_bridge #(.NUM_CH(NUM_CH), .CLKS_PER_BIT(CPB), .GUARD_BITS(GUARD)) u_dut (
    .clk, .rst_n, .regWrEn, .regWrData, .regRdData, .pulseIn, .txData, .txValid,
    .txBusy, .rxData, .rxValid, .frameErr, .pinIn, .pinOut, .pinOe
  );

  int compared = 0, mismatched = 0, rxCount = 0;
  logic [7:0] lastRx = '0;
  bit done = 0;

  always @(posedge clk) if (rst_n && rxValid) begin
    rxCount <= rxCount + 1;
    lastRx  <= rxData;
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [31:0] v);
    @(negedge clk); regWrData = v; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  // sends one frame and checks every bit at its middle; optional retrigger during bit 2
  task automatic txFrame(input logic [7:0] d, input int ch, input bit retrig);
    logic expBit;
    @(negedge clk); txData = d; txValid = 1'b1;
    @(posedge clk); @(negedge clk); txValid = 1'b0;
    repeat (CPB/2) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      expBit = (k == 0) ? 1'b0 : ((k == 9) ? 1'b1 : d[k-1]);
      chk($sformatf("R6 tx bit %0d of %h", k, d), {pinOe[ch], pinOut[ch]}, {1'b1, expBit});
      if (retrig && k == 2) begin
        txData = 8'h00; txValid = 1'b1;
        @(negedge clk); txValid = 1'b0;
        repeat (CPB-1) @(negedge clk);
      end else begin
        repeat (CPB) @(negedge clk);
      end
    end
    chk("R7 guard busy/released", {txBusy, pinOe[ch], pinOut[ch]}, 3'b101);
    repeat (GUARD*CPB) @(negedge clk);
    chk("R7 busy clear after guard", txBusy, 0);
  endtask

  task automatic rxFrame(input logic [7:0] d, input int ch, input logic stopLvl);
    @(negedge clk); extLine[ch] = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      extLine[ch] = d[k];
      repeat (CPB) @(negedge clk);
    end
    extLine[ch] = stopLvl;
    repeat (CPB) @(negedge clk);
    extLine[ch] = 1'b1;
    repeat (2*CPB) @(negedge clk);
  endtask

  // mode vectors: {ctrl[15:0], pulseIn, expOut, expOe}
  localparam int NMODE = 7;
  localparam logic [27:0] MODE_VEC [NMODE] = '{
    {16'h0001, 4'b1010, 4'b1010, 4'b1111},
    {16'h0004, 4'b1111, 4'b1111, 4'b1110},
    {16'h0204, 4'b0000, 4'b0100, 4'b1011},
    {16'h0214, 4'b1111, 4'b1011, 4'b1111},
    {16'h0314, 4'b0111, 4'b0111, 4'b1111},
    {16'h0000, 4'b1111, 4'b0000, 4'b1111},
    {16'h0005, 4'b0110, 4'b0111, 4'b1110}
  };

  localparam int NBYTE = 6;
  localparam logic [7:0] BYTES [NBYTE] = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h01, 8'h80};

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    int base;
    rst_n = 1'b0; regWrEn = 1'b0; regWrData = '0; txValid = 1'b0; txData = '0;
    extLine = 4'hF; pulseIn = 4'b1010;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 reg reset", regRdData, 32'h1);
    chk("R1 oe reset", pinOe, 4'hF);
    chk("R1 out follows pulse", pinOut, 4'b1010);
    chk("R1 flags reset", {txBusy, rxValid, frameErr}, 3'b000);

    // R2 R3 R4 R5 mode table
    for (int i = 0; i < NMODE; i++) begin
      wrReg({16'h0, MODE_VEC[i][27:12]});
      pulseIn = MODE_VEC[i][11:8];
      @(negedge clk);
      chk($sformatf("R2 R3 R4 R5 vec%0d out", i), pinOut, MODE_VEC[i][7:4]);
      chk($sformatf("R2 R3 R4 R5 vec%0d oe", i), pinOe, MODE_VEC[i][3:0]);
      chk($sformatf("R2 vec%0d readback", i), regRdData, {16'h0, MODE_VEC[i][27:12]});
    end

    // R6 R7 R9 R10 byte loop on channel 2
    wrReg(32'h0204);
    repeat (4) @(negedge clk);
    for (int i = 0; i < NBYTE; i++) begin
      base = rxCount;
      txFrame(BYTES[i], 2, 1'b0);
      chk("R9 no echo captured", rxCount, base);
      rxFrame(BYTES[i], 2, 1'b1);
      chk("R10 rx count", rxCount, base + 1);
      chk("R10 rx data", lastRx, BYTES[i]);
    end

    // R7 txValid during busy ignored
    base = rxCount;
    txFrame(8'hFF, 2, 1'b1);
    repeat (CPB) @(negedge clk);
    chk("R7 no second frame", {txBusy, pinOe[2]}, 2'b00);
    chk("R9 no echo after retrigger", rxCount, base);

    // R13 false start
    @(negedge clk); extLine[2] = 1'b0;
    repeat (CPB/4) @(negedge clk);
    extLine[2] = 1'b1;
    repeat (12*CPB) @(negedge clk);
    chk("R13 glitch no byte", rxCount, base);
    chk("R13 glitch no error", frameErr, 0);

    // R11 framing error, then sticky across a good frame
    rxFrame(8'h3C, 2, 1'b0);
    chk("R11 bad stop no byte", rxCount, base);
    chk("R11 error set", frameErr, 1);
    rxFrame(8'h96, 2, 1'b1);
    chk("R11 good frame after error", lastRx, 8'h96);
    chk("R11 error sticky", frameErr, 1);
    base = rxCount;

    // R5 break overrides a frame in progress and holds
    @(negedge clk); txData = 8'hFF; txValid = 1'b1;
    @(negedge clk); txValid = 1'b0;
    repeat (2*CPB) @(negedge clk);
    wrReg(32'h0214);
    @(negedge clk);
    chk("R5 break overrides tx", {pinOe[2], pinOut[2]}, 2'b10);
    for (int i = 0; i < 3; i++) begin
      repeat (1000) @(negedge clk);
      chk("R5 break held", {pinOe[2], pinOut[2]}, 2'b10);
    end
    chk("R12 no rx during break", rxCount, base);
    // R8 tx during break ignored
    @(negedge clk); txData = 8'h00; txValid = 1'b1;
    @(negedge clk); txValid = 1'b0;
    wrReg(32'h0204);
    @(negedge clk);
    chk("R8 tx ignored while forced", txBusy, 0);
    chk("R4 released after break", {pinOe[2], pinOut[2]}, 2'b01);
    repeat (12*CPB) @(negedge clk);
    chk("R12 nothing after release", rxCount, base);

    // R8 R12 in pulse mode
    wrReg(32'h0001);
    @(negedge clk); txData = 8'h00; txValid = 1'b1;
    @(negedge clk); txValid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 tx ignored in pulse mode", txBusy, 0);
    pulseIn = 4'b1110;
    repeat (11*CPB) @(negedge clk);
    chk("R2 pulse passthrough", pinOut, 4'b1110);
    pulseIn = 4'b1111;
    repeat (2*CPB) @(negedge clk);
    chk("R12 no rx in pulse mode", rxCount, base);

    finishRun();
  end

endmodule